// File: doc/BRIEF.md
# Identifier Arbitration Unit for a Wired-AND Message Bus

This unit handles the contention phase of a node on a shared multi-master bus. The bus is wired-AND: a low level is dominant and overrides a high, recessive level driven by any other node. On a request, the unit captures an 11-bit message identifier. It waits until the bus has been recessive long enough to count as free. It then drives one dominant start bit followed by the identifier, most significant bit first, at one bit per bit-time tick.

At each tick the unit compares the level it is driving with the level it reads back from the bus. A node that reads dominant while driving recessive has met a higher-priority message, meaning a numerically lower identifier. It pulses a loss flag, releases the line to recessive, and retries on its own once the bus is free again. A node whose last identifier bit reads back correctly pulses a win flag and has the bus for the rest of its frame, which is handled elsewhere. Reading recessive while driving dominant cannot come from another node, so it is reported as a bit error and the attempt is dropped.

Top module: `can_id_arbiter`

## Requirements
- R1: Out of reset the transmit level is recessive (1), `won`, `lost` and `bit_err` are 0, and `busy` is 0.
- R2: An attempt drives a dominant (0) start bit, then identifier bits 10 down to 0. Each level is held for exactly one tick period, and a dominant level is only driven while `busy` is 1.
- R3: When all 11 identifier bits read back as sent, `won` is 1 for exactly one clock cycle. The lower of two competing identifiers wins, and two nodes with equal identifiers both win.
- R4: At the tick where the bus reads dominant while the unit drives recessive, `lost` pulses for one cycle and the transmit level is recessive from then on. For a competitor that differs first at identifier bit b, this happens at the tick of frame bit 11-b, where frame bit 0 is the start bit.
- R5: After a loss the unit keeps `busy` at 1 and starts a new attempt with the same identifier without a new request.
- R6: A start bit is driven only at a tick whose bus sample is the twelfth consecutive recessive sample, that is, after 11 recessive bit times. While the bus is held dominant, no attempt starts.
- R7: At a tick where the bus reads recessive while the unit drives dominant, `bit_err` pulses for one cycle, the transmit level returns to recessive, and `busy` falls.
- R8: `req` is ignored while `busy` is 1. The identifier of the running attempt is unchanged, and no further attempt follows it.
- R9: At most one of `won`, `lost` and `bit_err` is 1 in any cycle, and `busy` is 0 in the cycle `won` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_tick | input | 1 | One-cycle pulse marking the sample point of each bit time |
| bus_rx | input | 1 | Bus level read back (0 dominant) |
| req | input | 1 | Request strobe that starts an arbitration |
| req_id | input | 11 | Identifier captured with `req` |
| tx_bit | output | 1 | Level driven onto the bus (1 recessive) |
| won | output | 1 | One-cycle pulse: arbitration won |
| lost | output | 1 | One-cycle pulse: arbitration lost, retry pending |
| bit_err | output | 1 | One-cycle pulse: dominant sent, recessive read |
| busy | output | 1 | An arbitration is pending or running |

## Verification
The bench sets the unit against a modelled competing node on a wired-AND bus. A lone sender shows that the serial order and the start bit are correct. Near-equal identifiers that differ only in low bits show the winner and the exact tick at which the loser drops out. The extreme pair, all zeros against all ones, makes the loss happen on the very first identifier bit. Equal identifiers show that nobody loses. A line forced recessive tells a bit error apart from a loss. A line held dominant shows that a start waits for twelve recessive samples. The retry after each loss shows the same rule applied to a bus just released by the winner.

// File: rtl/can_arb_pkg.sv
// Shared constants and the sequencer state type for the identifier
// arbitration unit. Assumes a single clock domain.
package can_arb_pkg;
    localparam int CAN_ID_W      = 11;
    localparam int CAN_IDLE_BITS = 11;

    typedef enum logic [1:0] {
        ARB_IDLE = 2'd0,   // no request held
        ARB_WAIT = 2'd1,   // request held, waiting for a free bus
        ARB_SEND = 2'd2    // start bit and identifier on the bus
    } arb_state_e;
endpackage

// File: rtl/can_bus_idle_mon.sv
// Counts consecutive recessive bus samples taken at the bit-time ticks
// and flags a free bus once IDLE_BITS of them have been seen. Any
// dominant sample restarts the count. Assumes bit_tick is a one-cycle pulse.
module can_bus_idle_mon #(
    parameter int IDLE_BITS = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_tick,
    input  logic bus_rx,
    output logic bus_free
);
    localparam int CNT_W = $clog2(IDLE_BITS + 1);
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(IDLE_BITS);

    logic [CNT_W-1:0] run_q;

    // Saturating run length of recessive samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (bit_tick) begin
            if (!bus_rx)
                run_q <= '0;
            else if (run_q != CNT_TOP)
                run_q <= run_q + 1'b1;
        end
    end

    assign bus_free = (run_q == CNT_TOP);

    // A dominant sample always withdraws the free indication (R6).
    assert_free_drops_on_dominant_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && !bus_rx) |=> !bus_free);
endmodule

// File: rtl/can_id_serializer.sv
// Selects the level for a given frame position: position 0 is the
// dominant start bit, positions 1..ID_W carry the identifier MSB first.
// Positions beyond the frame give recessive.
module can_id_serializer #(
    parameter int ID_W  = 11,
    parameter int POS_W = 4
) (
    input  logic [ID_W-1:0]  id,
    input  logic [POS_W-1:0] pos,
    output logic             bit_out
);
    logic [ID_W:0] frame;

    assign frame = {1'b0, id};

    // Position-indexed multiplexer over the start bit and identifier.
    always_comb begin
        bit_out = 1'b1;
        for (int k = 0; k <= ID_W; k++) begin
            if (pos == POS_W'(k))
                bit_out = frame[ID_W-k];
        end
    end
endmodule

// File: rtl/can_bit_check.sv
// Compares the driven level with the level read back at a sample point.
// Recessive out / dominant in is lost arbitration; dominant out /
// recessive in is a bit error. Purely combinational.
module can_bit_check (
    input  logic tx_bit,
    input  logic bus_rx,
    output logic lose_now,
    output logic err_now
);
    // Classify the two possible mismatches.
    always_comb begin
        lose_now = tx_bit & ~bus_rx;
        err_now  = ~tx_bit & bus_rx;
    end
endmodule

// File: rtl/can_id_arbiter.sv
// Node-side identifier arbitration. It holds a requested identifier, waits
// for a free bus, sends a dominant start bit and then the identifier MSB
// first, and checks every bit at the tick. On loss it backs off and retries;
// on a bit error it drops the request. Assumes bit_tick marks the sample
// point and that bus_rx is already synchronous to clk.
module can_id_arbiter
    import can_arb_pkg::*;
#(
    parameter int ID_W      = CAN_ID_W,
    parameter int IDLE_BITS = CAN_IDLE_BITS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bit_tick,
    input  logic            bus_rx,
    input  logic            req,
    input  logic [ID_W-1:0] req_id,
    output logic            tx_bit,
    output logic            won,
    output logic            lost,
    output logic            bit_err,
    output logic            busy
);
    localparam int POS_W = $clog2(ID_W + 1);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(ID_W);

    arb_state_e       state_q;
    logic [ID_W-1:0]  id_q;
    logic [POS_W-1:0] pos_q;
    logic [POS_W-1:0] pos_nxt;
    logic             tx_q;
    logic             won_q, lost_q, err_q;
    logic             bus_free;
    logic             ser_bit;
    logic             lose_now, err_now;

    can_bus_idle_mon #(.IDLE_BITS(IDLE_BITS)) u_idle (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_tick (bit_tick),
        .bus_rx   (bus_rx),
        .bus_free (bus_free)
    );

    assign pos_nxt = pos_q + 1'b1;

    can_id_serializer #(.ID_W(ID_W), .POS_W(POS_W)) u_ser (
        .id      (id_q),
        .pos     (pos_nxt),
        .bit_out (ser_bit)
    );

    can_bit_check u_chk (
        .tx_bit   (tx_q),
        .bus_rx   (bus_rx),
        .lose_now (lose_now),
        .err_now  (err_now)
    );

    // Arbitration sequencer: request capture, bus-free wait, bit stepping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ARB_IDLE;
            id_q    <= '0;
            pos_q   <= '0;
            tx_q    <= 1'b1;
            won_q   <= 1'b0;
            lost_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            won_q  <= 1'b0;
            lost_q <= 1'b0;
            err_q  <= 1'b0;
            case (state_q)
                ARB_IDLE: begin
                    if (req) begin
                        id_q    <= req_id;
                        state_q <= ARB_WAIT;
                    end
                end
                ARB_WAIT: begin
                    if (bit_tick && bus_free && bus_rx) begin
                        state_q <= ARB_SEND;
                        pos_q   <= '0;
                        tx_q    <= 1'b0;
                    end
                end
                ARB_SEND: begin
                    if (bit_tick) begin
                        if (lose_now) begin
                            lost_q  <= 1'b1;
                            tx_q    <= 1'b1;
                            state_q <= ARB_WAIT;
                        end else if (err_now) begin
                            err_q   <= 1'b1;
                            tx_q    <= 1'b1;
                            state_q <= ARB_IDLE;
                        end else if (pos_q == LAST_POS) begin
                            won_q   <= 1'b1;
                            tx_q    <= 1'b1;
                            state_q <= ARB_IDLE;
                        end else begin
                            pos_q <= pos_nxt;
                            tx_q  <= ser_bit;
                        end
                    end
                end
                default: begin
                    state_q <= ARB_IDLE;
                    tx_q    <= 1'b1;
                end
            endcase
        end
    end

    assign tx_bit  = tx_q;
    assign won     = won_q;
    assign lost    = lost_q;
    assign bit_err = err_q;
    assign busy    = (state_q != ARB_IDLE);

    // Outcome pulses never overlap (R9).
    assert_one_outcome_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({won_q, lost_q, err_q}));

    // A win releases the node in the same cycle (R9).
    assert_won_frees_R9: assert property (@(posedge clk) disable iff (!rst_n)
        won_q |-> !busy);

    // Dominant is only driven during an attempt (R2).
    assert_dominant_needs_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_q |-> busy);

    // Entering the send phase requires a free bus and a recessive sample (R6).
    assert_start_needs_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ARB_SEND && $past(state_q) != ARB_SEND) |-> ($past(bus_free) && $past(bus_rx)));

    // A comparator loss during sending leads to a lost pulse and recessive output (R4).
    assert_loss_recessive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ARB_SEND && bit_tick && lose_now) |=> (lost_q && tx_q));
endmodule

// File: tb/can_id_arbiter_tb.sv
module can_id_arbiter_tb;
    typedef enum int {EV_WON = 0, EV_LOST = 1, EV_ERR = 2} ev_e;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_tick = 1'b0;
    logic        req = 1'b0;
    logic [10:0] req_id = '0;
    logic        tx_bit, won, lost, bit_err, busy;
    logic        force_hi = 1'b0, force_lo = 1'b0;
    logic        comp_level = 1'b1;
    logic        bus_rx;

    assign bus_rx = force_hi ? 1'b1 : (tx_bit & comp_level & ~force_lo);

    always #5 clk = ~clk;

    can_id_arbiter u_dut (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .bus_rx(bus_rx),
        .req(req), .req_id(req_id), .tx_bit(tx_bit), .won(won),
        .lost(lost), .bit_err(bit_err), .busy(busy)
    );

    int   checks = 0, fails = 0;
    ev_e  exp_q[$];
    int   tick_div = 0;
    logic cap_rx = 1'b1;
    int   rec_cnt = 0;
    bit   dut_sending = 0;
    int   cap_idx = 0;
    logic tx_bits [12];
    int   lost_idx = -1;
    bit   comp_arm = 0, comp_run = 0;
    int   comp_pos = 0;
    logic [10:0] comp_id = '0;
    logic prev_won = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Tick generator, competing node, bus sampling and serial capture.
    always @(negedge clk) begin
        if (bit_tick) begin
            if (!dut_sending && !tx_bit) begin
                dut_sending = 1;
                cap_idx = 0;
                chk(rec_cnt >= 12, "R6 start after recessive run", rec_cnt, 12);
            end else if (dut_sending && (won || lost || bit_err)) begin
                if (lost) lost_idx = cap_idx;
                dut_sending = 0;
            end
            if (comp_run) begin
                if (comp_level && !cap_rx) begin
                    comp_run = 0; comp_level = 1'b1;
                end else if (comp_pos == 11) begin
                    comp_run = 0; comp_level = 1'b1;
                end else begin
                    comp_pos++;
                    comp_level = comp_id[11-comp_pos];
                end
            end else if (comp_arm && !tx_bit) begin
                comp_run = 1; comp_arm = 0; comp_pos = 0; comp_level = 1'b0;
            end
        end
        tick_div++;
        if (tick_div == 4) begin
            tick_div = 0;
            bit_tick = 1'b1;
            cap_rx = bus_rx;
            rec_cnt = cap_rx ? rec_cnt + 1 : 0;
            if (dut_sending && cap_idx < 12) begin
                tx_bits[cap_idx] = tx_bit;
                cap_idx++;
            end
        end else begin
            bit_tick = 1'b0;
        end
    end

    // Scoreboard monitor: pops expected outcomes as pulses appear.
    always @(negedge clk) begin
        if (rst_n && (won || lost || bit_err)) begin
            int act;
            act = won ? 0 : (lost ? 1 : 2);
            if (exp_q.size() == 0) begin
                chk(0, "R9 unexpected outcome", act, -1);
            end else begin
                ev_e e;
                e = exp_q.pop_front();
                chk(act == int'(e), "R3/R4/R7 outcome order", act, int'(e));
            end
            if (won) chk(busy == 1'b0, "R9 busy low with won", busy, 0);
            if (lost) chk(tx_bit == 1'b1, "R4 recessive after loss", tx_bit, 1);
            if (lost) chk(busy == 1'b1, "R5 still busy after loss", busy, 1);
        end
        if (rst_n && won && prev_won) chk(0, "R3 won one cycle", 2, 1);
        prev_won = won;
    end

    task automatic start_req(input logic [10:0] id);
        @(negedge clk); req = 1'b1; req_id = id;
        @(negedge clk); req = 1'b0;
    endtask

    task automatic wait_done();
        do @(negedge clk); while (busy || exp_q.size() != 0 || comp_run);
    endtask

    task automatic check_bits(input logic [10:0] id, input string tag);
        for (int k = 0; k < 12; k++) begin
            logic e;
            e = (k == 0) ? 1'b0 : id[11-k];
            chk(tx_bits[k] === e, tag, int'(tx_bits[k]), int'(e));
        end
    endtask

    function automatic int exp_loss_idx(input logic [10:0] a, input logic [10:0] b);
        for (int k = 10; k >= 0; k--)
            if (a[k] != b[k]) return 12 - k;
        return -1;
    endfunction

    task automatic contest(input logic [10:0] mine, input logic [10:0] other);
        comp_id = other; comp_arm = 1; lost_idx = -1;
        if (mine > other) begin exp_q.push_back(EV_LOST); exp_q.push_back(EV_WON); end
        else exp_q.push_back(EV_WON);
        start_req(mine);
        wait_done();
        if (mine > other) begin
            chk(lost_idx == exp_loss_idx(mine, other), "R4 loss bit position",
                lost_idx, exp_loss_idx(mine, other));
            check_bits(mine, "R5 retry frame");
        end else begin
            check_bits(mine, "R3 winning frame");
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(tx_bit == 1'b1, "R1 tx recessive", tx_bit, 1);
        chk({won, lost, bit_err} == 3'b000, "R1 flags low", {won, lost, bit_err}, 0);
        chk(busy == 1'b0, "R1 not busy", busy, 0);

        // R2/R8: lone sender, second request during the attempt is ignored
        exp_q.push_back(EV_WON);
        start_req(11'h5A3);
        wait (dut_sending);
        start_req(11'h000);
        wait_done();
        check_bits(11'h5A3, "R2 R8 frame order");
        repeat (120) @(negedge clk);
        chk(busy == 1'b0, "R8 no extra attempt", busy, 0);
        chk(tx_bit == 1'b1, "R8 line released", tx_bit, 1);

        // R3: lower identifier wins against a close rival
        contest(11'h100, 11'h101);
        // R4/R5: higher identifier loses at the differing bit and retries
        contest(11'h104, 11'h101);
        // R4: extremes, loss on the first identifier bit
        contest(11'h7FF, 11'h000);
        // R3: equal identifiers both win
        contest(11'h2AA, 11'h2AA);

        // R7: bus forced recessive turns the start bit into a bit error
        force_hi = 1'b1;
        exp_q.push_back(EV_ERR);
        start_req(11'h055);
        wait_done();
        force_hi = 1'b0;
        chk(busy == 1'b0, "R7 request dropped", busy, 0);
        chk(tx_bit == 1'b1, "R7 line recessive", tx_bit, 1);

        // R6: a dominant-held bus blocks the start
        force_lo = 1'b1;
        start_req(11'h321);
        repeat (160) @(negedge clk);
        chk(busy == 1'b1, "R6 waiting while held", busy, 1);
        chk(tx_bit == 1'b1, "R6 no start while held", tx_bit, 1);
        chk(dut_sending == 0, "R6 no frame while held", int'(dut_sending), 0);
        exp_q.push_back(EV_WON);
        force_lo = 1'b0;
        wait_done();
        check_bits(11'h321, "R6 frame after release");

        repeat (20) @(negedge clk);
        chk(exp_q.size() == 0, "R9 all outcomes seen", exp_q.size(), 0);
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end
endmodule